// File: doc/BRIEF.md
# ADC Acquisition Trigger and Scan Controller

This block is the register-controlled front end of a 16-channel sampling converter. A host reads and writes a small register file through a simple strobe bus with a 4-bit word address. Through that file it picks what launches each conversion: a software write, a pacer tick or an external trigger pulse. It also picks whether conversions stay on one channel or sweep upward from channel 0 to a programmed top channel. The converter itself is modelled as a busy interval of `CONV_LAT` cycles. At the end of that interval the value on `adc_result` is captured into a 1024-entry sample FIFO.

The host drains the FIFO through a data port. It watches FIFO state in a status byte whose full and half-full flags are active low. The FIFO can only be emptied by a three-write pulse sequence on an enable bit. Two interrupt lines are latched from selectable sources and dropped by a write to a clear register. The register map is: 0 FIFO data, 1 channel, 2 gain/status, 3 trigger control, 4 interrupt control, 5 software trigger, 6 interrupt clear.

Top module: `adc_acq_ctrl`

## Requirements
- R1: After reset, the status register (address 2) reads 0x60, which means idle, not full, not half full, empty, no overflow and gain 0. Both `irq0` and `irq1` are low.
- R2: Trigger control (address 3) bit 2 selects `ext_trig` as the conversion source. Otherwise bit 1 selects `pacer_tick`. When both are 0, a write of any value to address 5 is the source. Requests from sources that are not selected start nothing.
- R3: With auto-scan (trigger control bit 0) off, every conversion uses the channel register value (address 1, bits 3:0), which appears on `conv_chan`.
- R4: With auto-scan on, conversions use channels 0, 1, … up to the channel register value and then wrap to 0. A write to the channel register restarts the sweep at 0.
- R5: A conversion keeps status bit 7 (busy) high for `CONV_LAT` cycles. The sample becomes readable `CONV_LAT` cycles after the starting edge. A request that arrives while busy is ignored.
- R6: The gain code is written to address 2, bits 2:0. It reads back in the same bits of the status register and drives `conv_gain`.
- R7: Samples leave the FIFO at address 0 in arrival order. Status bit 4 is 1 while data is present. Status bit 5 is 0 while 512 or more samples are held.
- R8: Status bit 6 is 0 when 1024 samples are held. A sample that completes while the FIFO is full is dropped, and it sets the sticky overflow status bit 3 until the next FIFO clear.
- R9: The FIFO and the overflow bit are cleared only when three successive writes to interrupt control (address 4) carry bit 2 as 0, then 1, then 0.
- R10: A read of address 0 while the FIFO is empty returns the last value read and leaves the FIFO empty.
- R11: Interrupt control bit 0 picks the source of `irq0`: 0 means end of conversion, 1 means FIFO at least half full.
- R12: Interrupt control bit 1 picks the source of `irq1`: 0 means a `pacer_tick` pulse, 1 means an `ext_trig` pulse. Any write to address 6 drops both lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the FIFO at address 0) |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| pacer_tick | input | 1 | Pacer pulse, one cycle |
| ext_trig | input | 1 | External trigger pulse, one cycle, synchronous |
| adc_result | input | 16 | Converter output, captured when a conversion completes |
| conv_chan | output | 4 | Channel of the current or last conversion |
| conv_gain | output | 3 | Gain code applied to all channels |
| irq0 | output | 1 | Interrupt line 0 |
| irq1 | output | 1 | Interrupt line 1 |

## Verification
A wrong scan index shows up at the data port on the first conversion after the fault, because each captured sample carries the channel that produced it. A corrupted FIFO count or pointer shows up on the next status read, either as a wrong not-empty or half-full bit or as words returned out of order. A fault in the clear-sequence tracker shows up as a FIFO that empties on the wrong write sequence, or fails to empty on the right one. A busy counter that is off by one moves the not-empty bit one cycle away from the expected edge.

// File: rtl/adc_acq_pkg.sv
// Shared register addresses and trigger source encoding for the acquisition controller.
package adc_acq_pkg;
    localparam logic [3:0] A_DATA  = 4'd0;
    localparam logic [3:0] A_CHAN  = 4'd1;
    localparam logic [3:0] A_GAIN  = 4'd2;
    localparam logic [3:0] A_TRIG  = 4'd3;
    localparam logic [3:0] A_INTC  = 4'd4;
    localparam logic [3:0] A_SOFT  = 4'd5;
    localparam logic [3:0] A_ICLR  = 4'd6;

    typedef enum logic [1:0] {
        SRC_SOFT  = 2'd0,
        SRC_PACER = 2'd1,
        SRC_EXT   = 2'd2
    } trig_src_e;
endpackage

// File: rtl/adc_acq_regs.sv
// Register file: holds channel, gain, trigger and interrupt controls, decodes
// strobe registers and tracks the 0-1-0 enable sequence that clears the FIFO.
// Assumes one write per cycle and that bus_addr is stable while bus_wr is high.
module adc_acq_regs
    import adc_acq_pkg::*;
#(
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [3:0]      addr,
    input  logic [7:0]      wdata,
    output logic [CH_W-1:0] chan_reg,
    output logic            chan_wr,
    output logic [2:0]      gain,
    output logic [3:0]      trig_ctl,
    output trig_src_e       src,
    output logic            isrc0,
    output logic            isrc1,
    output logic            fifo_en,
    output logic            fifo_clr,
    output logic            soft_trig,
    output logic            irq_clr
);
    logic       intc_wr;
    logic [1:0] seq_stage;

    assign chan_wr   = wr && (addr == A_CHAN);
    assign intc_wr   = wr && (addr == A_INTC);
    assign soft_trig = wr && (addr == A_SOFT);
    assign irq_clr   = wr && (addr == A_ICLR);
    assign fifo_clr  = intc_wr && !wdata[2] && (seq_stage == 2'd2);

    // Source decode: external outranks pacer, neither means software.
    always_comb begin
        if (trig_ctl[2])      src = SRC_EXT;
        else if (trig_ctl[1]) src = SRC_PACER;
        else                  src = SRC_SOFT;
    end

    // Holds the programmable control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_reg <= '0;
            gain     <= '0;
            trig_ctl <= '0;
            isrc0    <= 1'b0;
            isrc1    <= 1'b0;
            fifo_en  <= 1'b0;
        end else if (wr) begin
            case (addr)
                A_CHAN: chan_reg <= wdata[CH_W-1:0];
                A_GAIN: gain     <= wdata[2:0];
                A_TRIG: trig_ctl <= wdata[3:0];
                A_INTC: begin
                    isrc0   <= wdata[0];
                    isrc1   <= wdata[1];
                    fifo_en <= wdata[2];
                end
                default: ;
            endcase
        end
    end

    // Tracks how much of the 0,1,0 enable sequence the last writes formed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_stage <= 2'd0;
        end else if (intc_wr) begin
            if (!wdata[2])              seq_stage <= 2'd1;
            else if (seq_stage == 2'd1) seq_stage <= 2'd2;
            else                        seq_stage <= 2'd0;
        end
    end

    // R9
    clr_after_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |-> fifo_en);
endmodule

// File: rtl/adc_acq_seq.sv
// Conversion sequencer: starts a conversion on a request when idle, picks the
// fixed or scanned channel, holds busy for CONV_LAT cycles and flags completion.
// Assumes CONV_LAT >= 1; a request while busy is dropped.
module adc_acq_seq #(
    parameter int CH_W     = 4,
    parameter int CONV_LAT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_req,
    input  logic            autoscan,
    input  logic [CH_W-1:0] chan_reg,
    input  logic            chan_wr,
    output logic            busy,
    output logic            done,
    output logic [CH_W-1:0] conv_chan
);
    localparam int CW = (CONV_LAT > 1) ? $clog2(CONV_LAT) : 1;
    localparam logic [CW-1:0] CNT_INIT = CW'(CONV_LAT - 1);

    logic [CW-1:0]   cnt;
    logic [CH_W-1:0] scan_idx;
    logic            start;

    assign start = start_req && !busy;
    assign done  = busy && (cnt == '0);

    // Busy interval counter and channel capture at conversion start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            cnt       <= '0;
            conv_chan <= '0;
        end else if (start) begin
            busy      <= 1'b1;
            cnt       <= CNT_INIT;
            conv_chan <= autoscan ? scan_idx : chan_reg;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    // Scan position: restarts on a channel write, advances and wraps per scanned start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_idx <= '0;
        end else if (chan_wr) begin
            scan_idx <= '0;
        end else if (start && autoscan) begin
            scan_idx <= (scan_idx >= chan_reg) ? '0 : scan_idx + 1'b1;
        end
    end

    // R5
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R5
    busy_holds_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (busy && conv_chan == $past(conv_chan)));
endmodule

// File: rtl/adc_acq_fifo.sv
// Sample FIFO with count-based flags, sticky overflow, drop-on-full and a
// read port that repeats the last popped word when empty.
// Assumes DEPTH is a power of two.
module adc_acq_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 1024
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full,
    output logic         half,
    output logic         ovf
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);
    localparam logic [AW:0] HALF_LVL = (AW+1)'(DEPTH / 2);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [AW:0]   count;
    logic [W-1:0]  last_rd;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == FULL_LVL);
    assign half    = (count >= HALF_LVL);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = empty ? last_rd : mem[rptr];

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    // Pointers, occupancy, overflow flag and last-read holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            ovf     <= 1'b0;
            last_rd <= '0;
        end else if (clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop) begin
                rptr    <= rptr + 1'b1;
                last_rd <= mem[rptr];
            end
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
            if (push && full)            ovf <= 1'b1;
        end
    end

    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_LVL);
    // R8
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (full && ovf));
    // R10
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !clr) |=> (empty && $stable(last_rd)));
endmodule

// File: rtl/adc_acq_irq.sv
// Interrupt latches: each line sets from its selected source and drops on a
// clear strobe; a clear in the same cycle as a set wins.
module adc_acq_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic isrc0,
    input  logic isrc1,
    input  logic conv_done,
    input  logic fifo_half,
    input  logic pacer_tick,
    input  logic ext_trig,
    input  logic irq_clr,
    output logic irq0,
    output logic irq1
);
    logic set0, set1;

    assign set0 = isrc0 ? fifo_half : conv_done;
    assign set1 = isrc1 ? ext_trig  : pacer_tick;

    // Pending latches for both lines.
    always_ff @(posedge clk) begin
        if (!rst_n || irq_clr) begin
            irq0 <= 1'b0;
            irq1 <= 1'b0;
        end else begin
            if (set0) irq0 <= 1'b1;
            if (set1) irq1 <= 1'b1;
        end
    end

    // R12
    clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr |=> (!irq0 && !irq1));
endmodule

// File: rtl/adc_acq_ctrl.sv
// Top of the acquisition controller: routes the selected trigger to the
// sequencer, pushes completed samples into the FIFO, raises interrupts and
// serves register reads. Reads are combinational; a read of the data port pops.
module adc_acq_ctrl
    import adc_acq_pkg::*;
#(
    parameter int CH_W       = 4,
    parameter int SAMPLE_W   = 16,
    parameter int FIFO_DEPTH = 1024,
    parameter int CONV_LAT   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [3:0]          bus_addr,
    input  logic [7:0]          bus_wdata,
    output logic [15:0]         bus_rdata,
    input  logic                pacer_tick,
    input  logic                ext_trig,
    input  logic [SAMPLE_W-1:0] adc_result,
    output logic [CH_W-1:0]     conv_chan,
    output logic [2:0]          conv_gain,
    output logic                irq0,
    output logic                irq1
);
    logic [CH_W-1:0]     chan_reg;
    logic                chan_wr, isrc0, isrc1, fifo_en, fifo_clr, soft_trig, irq_clr;
    logic [2:0]          gain;
    logic [3:0]          trig_ctl;
    trig_src_e           src;
    logic                start_req, busy, done;
    logic                f_empty, f_full, f_half, f_ovf, pop;
    logic [SAMPLE_W-1:0] f_dout;
    logic [7:0]          status;

    adc_acq_regs #(.CH_W(CH_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .chan_reg(chan_reg), .chan_wr(chan_wr), .gain(gain), .trig_ctl(trig_ctl),
        .src(src), .isrc0(isrc0), .isrc1(isrc1), .fifo_en(fifo_en),
        .fifo_clr(fifo_clr), .soft_trig(soft_trig), .irq_clr(irq_clr)
    );

    // Selected trigger source feeding the sequencer.
    always_comb begin
        case (src)
            SRC_EXT:   start_req = ext_trig;
            SRC_PACER: start_req = pacer_tick;
            default:   start_req = soft_trig;
        endcase
    end

    adc_acq_seq #(.CH_W(CH_W), .CONV_LAT(CONV_LAT)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .autoscan(trig_ctl[0]),
        .chan_reg(chan_reg), .chan_wr(chan_wr), .busy(busy), .done(done),
        .conv_chan(conv_chan)
    );

    assign pop = bus_rd && (bus_addr == A_DATA);

    adc_acq_fifo #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .push(done), .din(adc_result),
        .pop(pop), .dout(f_dout), .empty(f_empty), .full(f_full), .half(f_half),
        .ovf(f_ovf)
    );

    adc_acq_irq u_irq (
        .clk(clk), .rst_n(rst_n), .isrc0(isrc0), .isrc1(isrc1), .conv_done(done),
        .fifo_half(f_half), .pacer_tick(pacer_tick), .ext_trig(ext_trig),
        .irq_clr(irq_clr), .irq0(irq0), .irq1(irq1)
    );

    assign conv_gain = gain;
    assign status    = {busy, ~f_full, ~f_half, ~f_empty, f_ovf, gain};

    // Register read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_DATA: bus_rdata = 16'(f_dout);
            A_CHAN: bus_rdata = 16'(chan_reg);
            A_GAIN: bus_rdata = {8'h00, status};
            A_TRIG: bus_rdata = {12'h000, trig_ctl};
            A_INTC: bus_rdata = {13'h0000, fifo_en, isrc1, isrc0};
            default: bus_rdata = '0;
        endcase
    end

    // R2
    no_start_unselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_req) |=> !busy);
endmodule

// File: tb/adc_acq_ctrl_tb.sv
module adc_acq_ctrl_tb;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        pacer_tick = 1'b0, ext_trig = 1'b0;
    logic [11:0] res_hi = 12'hAB0;
    logic [15:0] adc_result;
    logic [3:0]  conv_chan;
    logic [2:0]  conv_gain;
    logic        irq0, irq1;
    int          checks = 0, errors = 0;

    assign adc_result = {res_hi, conv_chan};

    adc_acq_ctrl #(.CONV_LAT(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pacer_tick(pacer_tick), .ext_trig(ext_trig), .adc_result(adc_result),
        .conv_chan(conv_chan), .conv_gain(conv_gain), .irq0(irq0), .irq1(irq1)
    );

    always #4 clk = ~clk;

    // Vector: ctl[15:12] chan[11:8] write_chan[7] src[6:5] expect_conv[4] expect_chan[3:0]
    localparam logic [15:0] VEC [14] = '{
        16'h0595, 16'h0020, 16'h0040, 16'h27B7, 16'h2000, 16'h4057, 16'h4020,
        16'h1290, 16'h1011, 16'h1012, 16'h1010, 16'h3031, 16'h6020, 16'h6052
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input logic [1:0] s);
        if (s == 2'd0) wr(4'd5, 8'h00);
        else begin
            if (s == 2'd1) pacer_tick = 1'b1; else ext_trig = 1'b1;
            @(negedge clk);
            pacer_tick = 1'b0; ext_trig = 1'b0;
        end
    endtask

    task automatic soft_conv();
        wr(4'd5, 8'h00);
        repeat (LAT) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [15:0] v;
        logic [15:0] e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'd2, v); chk("R1 status", v, 16'h0060);
        chk("R1 irqs", {14'h0, irq1, irq0}, 16'h0000);

        // R2 R3 R4 vector table
        foreach (VEC[i]) begin
            e = VEC[i];
            wr(4'd3, {4'h0, e[15:12]});
            if (e[7]) wr(4'd1, {4'h0, e[11:8]});
            pulse(e[6:5]);
            repeat (LAT + 1) @(negedge clk);
            rd(4'd2, v);
            chk($sformatf("R2 vec%0d not-empty", i), {15'h0, v[4]}, {15'h0, e[4]});
            if (e[4]) begin
                rd(4'd0, v);
                chk($sformatf("R3/R4 vec%0d channel", i), v, {12'hAB0, e[3:0]});
            end
        end
        wr(4'd3, 8'h00);
        wr(4'd1, 8'h03);

        // R6 gain readback and output
        wr(4'd2, 8'h05);
        rd(4'd2, v); chk("R6 gain status", v, 16'h0065);
        chk("R6 conv_gain", {13'h0, conv_gain}, 16'h0005);

        // R5 latency edge
        wr(4'd5, 8'h00);
        repeat (LAT - 1) @(negedge clk);
        rd(4'd2, v); chk("R5 before latency", {15'h0, v[4]}, 16'h0000);
        rd(4'd2, v); chk("R5 at latency", {15'h0, v[4]}, 16'h0001);
        rd(4'd0, v);

        // R5 busy flag and request during busy ignored
        wr(4'd5, 8'h00);
        rd(4'd2, v); chk("R5 busy bit", {15'h0, v[7]}, 16'h0001);
        wr(4'd5, 8'h00);
        repeat (2 * LAT) @(negedge clk);
        rd(4'd0, v);
        rd(4'd2, v); chk("R5 one sample only", {15'h0, v[4]}, 16'h0000);

        // R10 order and empty read repeats last value
        res_hi = 12'h111; soft_conv();
        res_hi = 12'h222; soft_conv();
        rd(4'd0, v); chk("R7 first out", v, 16'h1113);
        rd(4'd0, v); chk("R7 second out", v, 16'h2223);
        rd(4'd0, v); chk("R10 empty read", v, 16'h2223);
        rd(4'd2, v); chk("R10 still empty", {15'h0, v[4]}, 16'h0000);

        // R9 clear sequence: 1,1,0 keeps data; 0,1,0 clears
        soft_conv(); soft_conv();
        wr(4'd4, 8'h04); wr(4'd4, 8'h04); wr(4'd4, 8'h00);
        rd(4'd2, v); chk("R9 no clear on 1,1,0", {15'h0, v[4]}, 16'h0001);
        wr(4'd4, 8'h04); wr(4'd4, 8'h00);
        rd(4'd2, v); chk("R9 clear on 0,1,0", {15'h0, v[4]}, 16'h0000);

        // R11 end-of-conversion interrupt
        wr(4'd6, 8'h00);
        chk("R12 clear", {15'h0, irq0}, 16'h0000);
        soft_conv();
        chk("R11 irq0 eoc", {15'h0, irq0}, 16'h0001);
        wr(4'd6, 8'h00);
        chk("R12 irq0 cleared", {15'h0, irq0}, 16'h0000);
        rd(4'd0, v);

        // R12 interrupt 1 sources
        pulse(2'd1);
        chk("R12 irq1 pacer", {15'h0, irq1}, 16'h0001);
        wr(4'd6, 8'h00);
        chk("R12 irq1 cleared", {15'h0, irq1}, 16'h0000);
        wr(4'd4, 8'h02);
        pulse(2'd1);
        chk("R12 pacer ignored", {15'h0, irq1}, 16'h0000);
        pulse(2'd2);
        chk("R12 irq1 ext", {15'h0, irq1}, 16'h0001);

        // R7 R8 R11 fill to half and full
        res_hi = 12'h5A5;
        wr(4'd4, 8'h01); wr(4'd6, 8'h00);
        for (int n = 0; n < 511; n++) soft_conv();
        rd(4'd2, v); chk("R7 511 not half", {14'h0, v[5:4]}, 16'h0003);
        chk("R11 irq0 below half", {15'h0, irq0}, 16'h0000);
        soft_conv();
        rd(4'd2, v); chk("R7 512 half", {14'h0, v[5:4]}, 16'h0001);
        chk("R11 irq0 at half", {15'h0, irq0}, 16'h0001);
        for (int n = 0; n < 512; n++) soft_conv();
        rd(4'd2, v); chk("R8 full flag", {12'h0, v[6:3]}, 16'h0002);
        soft_conv();
        rd(4'd2, v); chk("R8 overflow sticky", {12'h0, v[6:3]}, 16'h0003);
        for (int n = 0; n < 1024; n++) rd(4'd0, v);
        chk("R8 last kept word", v, 16'h5A53);
        rd(4'd2, v); chk("R8 drained, ovf held", {14'h0, v[4:3]}, 16'h0001);
        wr(4'd4, 8'h00); wr(4'd4, 8'h04); wr(4'd4, 8'h00);
        rd(4'd2, v); chk("R9 ovf cleared", {15'h0, v[3]}, 16'h0000);

        summary();
    end
endmodule